// File: doc/BRIEF.md
# Crosspoint Routing Matrix Parallel Command Interface

This block is the digital control path of an eight-output, eight-input video routing matrix. It is driven in parallel mode. A host presents a 3-bit output address and a 4-bit code. A chip-enable-gated write strobe then captures the word into a bank of per-output staging registers. A second bank of registers, the live bank, drives the switch decoders. Only the live bank decides which input each output carries and whether that output's buffer input is grounded.

The live bank is loaded in one of three ways. The first is a rising edge on the transfer pin, when the mode pin is high. The second is transparent following while the transfer pin is low, when the mode pin is low. The third is a software transfer command, issued while the transfer pin is high. Other codes in the upper half of the code space switch output buffers on and off, either one at a time or all together, and leave the routing untouched. All pins are synchronised to the system clock, and their edges are found in that domain.

Top module: `xpt_ctrl`

## Requirements
- R1: After reset every bit of `buf_en_o` is 0.
- R2: A word is taken only on a rising edge of the gated strobe, where gated strobe = `wr_i` AND `ce_i` AND NOT `ce_n_i`. Strobes with `ce_i`=0 or `ce_n_i`=1 change nothing.
- R3: A code from 4'b0000 to 4'b0111 stages input number code[2:0] for the addressed output and clears its ground flag. After a transfer, `route_sel_o[3*k+:3]` shows that number and `gnd_sel_o[k]` is 0.
- R4: Code 4'b1000 stages the ground flag for the addressed output. The staged input number is kept. After a transfer, `gnd_sel_o[k]` is 1.
- R5: Code 4'b1011 clears `buf_en_o[addr]`. Code 4'b1100 sets it again. Neither code changes the routing outputs.
- R6: Code 4'b1101 clears all of `buf_en_o`. Code 4'b1110 sets all of it.
- R7: Code 4'b1111 copies the staging bank into the live bank when the synchronised transfer pin is high. It has no effect when the pin is low.
- R8: With `edge_mode_i`=1, the live bank changes only on a rising edge of `latch_i` or through R7. Staged writes alone do not reach the outputs.
- R9: With `edge_mode_i`=0, the live bank follows the staging bank while `latch_i` is low and holds while `latch_i` is high.
- R10: Codes 4'b1001 and 4'b1010 change neither bank and no buffer enable.
- R11: Several writes to different outputs followed by one transfer edge update all those outputs in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, acts on its rising edge |
| ce_n_i | input | 1 | Active-low chip enable |
| ce_i | input | 1 | Active-high chip enable |
| addr_i | input | 3 | Output address of the command word |
| code_i | input | 4 | Code of the command word |
| latch_i | input | 1 | Transfer pin, staging bank to live bank |
| edge_mode_i | input | 1 | 1: transfer on rising edge, 0: transparent while low |
| route_sel_o | output | 24 | Selected input per output, 3 bits each, output k at bits 3k+2..3k |
| gnd_sel_o | output | 8 | Per-output buffer-input ground flag |
| buf_en_o | output | 8 | Per-output buffer enable |

## Verification
The bench targets the ways the staging and live banks can leak into each other.

- A design that lets writes pass straight through in edge mode shows a new route before any transfer edge.
- A design that ignores the transfer-pin condition on the software transfer command copies the staging bank while the pin is low.
- A design that updates outputs one write at a time, or that staggers the bank copy, shows two outputs changing in different cycles after a single edge.
- A design that decodes the reserved codes as routes, or that drops one chip enable from the gate, shows a changed route or enable vector.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] OP_GROUND  = 4'b1000;
    localparam logic [CODE_W-1:0] OP_RSV_LO  = 4'b1001;
    localparam logic [CODE_W-1:0] OP_RSV_HI  = 4'b1010;
    localparam logic [CODE_W-1:0] OP_BUF_OFF = 4'b1011;
    localparam logic [CODE_W-1:0] OP_BUF_ON  = 4'b1100;
    localparam logic [CODE_W-1:0] OP_ALL_OFF = 4'b1101;
    localparam logic [CODE_W-1:0] OP_ALL_ON  = 4'b1110;
    localparam logic [CODE_W-1:0] OP_SW_XFER = 4'b1111;

    typedef struct packed {
        logic route;
        logic ground;
        logic buf_off;
        logic buf_on;
        logic all_off;
        logic all_on;
        logic sw_xfer;
    } cmd_act_t;

endpackage

// File: rtl/xpt_pin_sync.sv
`timescale 1ns/1ps
module xpt_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);

    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign lvl_o = chain_q[STAGES-1];

endmodule

// File: rtl/xpt_cmd_decode.sv
`timescale 1ns/1ps
module xpt_cmd_decode
    import xpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lvl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              fire_o,
    output cmd_act_t          act_o
);

    typedef struct packed {
        logic wr_prev;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_lvl_i;
        fire_o       = wr_lvl_i & ~st_q.wr_prev;
        act_o        = '0;
        if (fire_o) begin
            if (!code_i[CODE_W-1]) begin
                act_o.route = 1'b1;
            end else begin
                case (code_i)
                    OP_GROUND:  act_o.ground  = 1'b1;
                    OP_BUF_OFF: act_o.buf_off = 1'b1;
                    OP_BUF_ON:  act_o.buf_on  = 1'b1;
                    OP_ALL_OFF: act_o.all_off = 1'b1;
                    OP_ALL_ON:  act_o.all_on  = 1'b1;
                    OP_SW_XFER: act_o.sw_xfer = 1'b1;
                    default:    act_o         = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // One strobe edge yields one command, never two in a row
    p_single_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

endmodule

// File: rtl/xpt_rank_regs.sv
`timescale 1ns/1ps
module xpt_rank_regs
    import xpt_pkg::*;
#(
    parameter int N_OUT  = 8,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cmd_act_t                act_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic                    latch_lvl_i,
    input  logic                    edge_mode_i,
    output logic [N_OUT*SEL_W-1:0]  route_sel_o,
    output logic [N_OUT-1:0]        gnd_sel_o,
    output logic [N_OUT-1:0]        buf_en_o
);

    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] stage_sel;
        logic [N_OUT-1:0]            stage_gnd;
        logic [N_OUT-1:0][SEL_W-1:0] live_sel;
        logic [N_OUT-1:0]            live_gnd;
        logic [N_OUT-1:0]            buf_en;
        logic                        latch_prev;
    } rank_state_t;

    rank_state_t st_d, st_q;
    logic        latch_rise;
    logic        xfer;

    always_comb begin
        st_d            = st_q;
        st_d.latch_prev = latch_lvl_i;
        latch_rise      = latch_lvl_i & ~st_q.latch_prev;
        xfer            = edge_mode_i ? latch_rise : ~latch_lvl_i;
        if (act_i.sw_xfer && latch_lvl_i) xfer = 1'b1;

        if (act_i.route) begin
            st_d.stage_sel[addr_i] = sel_i;
            st_d.stage_gnd[addr_i] = 1'b0;
        end
        if (act_i.ground) st_d.stage_gnd[addr_i] = 1'b1;

        if (xfer) begin
            st_d.live_sel = st_q.stage_sel;
            st_d.live_gnd = st_q.stage_gnd;
        end

        if (act_i.buf_off) st_d.buf_en[addr_i] = 1'b0;
        if (act_i.buf_on)  st_d.buf_en[addr_i] = 1'b1;
        if (act_i.all_off) st_d.buf_en         = '0;
        if (act_i.all_on)  st_d.buf_en         = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign route_sel_o[k*SEL_W +: SEL_W] = st_q.live_sel[k];
    end
    assign gnd_sel_o = st_q.live_gnd;
    assign buf_en_o  = st_q.buf_en;

    p_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.all_off |=> (buf_en_o == '0));
    p_all_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.all_on |=> (&buf_en_o));
    p_buf_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_i.buf_off |=> !buf_en_o[$past(addr_i)]);
    p_buf_cmd_keeps_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_i.buf_off || act_i.buf_on) && edge_mode_i && !latch_rise)
        |=> $stable(route_sel_o) && $stable(gnd_sel_o));
    p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && !latch_rise && !act_i.sw_xfer)
        |=> $stable(route_sel_o) && $stable(gnd_sel_o));
    p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && latch_lvl_i && !act_i.sw_xfer)
        |=> $stable(route_sel_o) && $stable(gnd_sel_o));

endmodule

// File: rtl/xpt_ctrl.sv
`timescale 1ns/1ps
module xpt_ctrl
    import xpt_pkg::*;
#(
    parameter  int N_OUT       = 8,
    parameter  int N_IN        = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(N_OUT),
    localparam int SEL_W       = $clog2(N_IN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   ce_n_i,
    input  logic                   ce_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [CODE_W-1:0]      code_i,
    input  logic                   latch_i,
    input  logic                   edge_mode_i,
    output logic [N_OUT*SEL_W-1:0] route_sel_o,
    output logic [N_OUT-1:0]       gnd_sel_o,
    output logic [N_OUT-1:0]       buf_en_o
);

    localparam int PIN_W = 3;

    logic             wr_gated;
    logic [PIN_W-1:0] pin_lvl;
    logic             dec_fire;
    cmd_act_t         dec_act;

    assign wr_gated = wr_i & ce_i & ~ce_n_i;

    xpt_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({edge_mode_i, latch_i, wr_gated}),
        .lvl_o (pin_lvl)
    );

    xpt_cmd_decode i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lvl_i (pin_lvl[0]),
        .code_i   (code_i),
        .fire_o   (dec_fire),
        .act_o    (dec_act)
    );

    xpt_rank_regs #(.N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) i_ranks (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (dec_act),
        .addr_i      (addr_i),
        .sel_i       (code_i[SEL_W-1:0]),
        .latch_lvl_i (pin_lvl[1]),
        .edge_mode_i (pin_lvl[2]),
        .route_sel_o (route_sel_o),
        .gnd_sel_o   (gnd_sel_o),
        .buf_en_o    (buf_en_o)
    );

    p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_fire && (code_i == OP_RSV_LO || code_i == OP_RSV_HI))
        |=> $stable(buf_en_o));
    p_reserved_no_act_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == OP_RSV_LO || code_i == OP_RSV_HI) |-> (dec_act == '0));

endmodule

// File: tb/test_xpt_ctrl.sv
`timescale 1ns/1ps
module test_xpt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, ce_n = 1'b0, ce = 1'b1;
    logic [2:0]  addr = '0;
    logic [3:0]  code = '0;
    logic        latch = 1'b1, edge_mode = 1'b1;
    logic [23:0] route_sel;
    logic [7:0]  gnd_sel, buf_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    xpt_ctrl i_xpt_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .ce_n_i(ce_n), .ce_i(ce),
        .addr_i(addr), .code_i(code), .latch_i(latch), .edge_mode_i(edge_mode),
        .route_sel_o(route_sel), .gnd_sel_o(gnd_sel), .buf_en_o(buf_en)
    );

    // {addr[2:0], code[3:0], expected sel[2:0], expected gnd}
    localparam logic [10:0] VEC [8] = '{
        {3'd0, 4'b0101, 3'd5, 1'b0},
        {3'd1, 4'b0000, 3'd0, 1'b0},
        {3'd2, 4'b0111, 3'd7, 1'b0},
        {3'd3, 4'b1000, 3'd0, 1'b1},
        {3'd4, 4'b0011, 3'd3, 1'b0},
        {3'd5, 4'b1000, 3'd0, 1'b1},
        {3'd7, 4'b0110, 3'd6, 1'b0},
        {3'd5, 4'b0010, 3'd2, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [2:0] a, input logic [3:0] c);
        @(negedge clk);
        addr = a; code = c; wr = 1'b1;
        idle(4);
        wr = 1'b0;
        idle(4);
    endtask

    task automatic pulse_latch();
        latch = 1'b0;
        idle(4);
        latch = 1'b1;
        idle(5);
    endtask

    function automatic logic [2:0] sel_of(input int k);
        return route_sel[k*3 +: 3];
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(6);
        chk("R1 reset buf_en", buf_en, 8'h00);

        put(3'd0, 4'b1110);
        chk("R6 all on", buf_en, 8'hFF);

        for (int i = 0; i < 8; i++) begin
            put(VEC[i][10:8], VEC[i][7:4]);
            pulse_latch();
            chk(VEC[i][7] ? "R4 ground sel" : "R3 route sel", sel_of(VEC[i][10:8]), VEC[i][3:1]);
            chk(VEC[i][7] ? "R4 ground flag" : "R3 ground flag", gnd_sel[VEC[i][10:8]], VEC[i][0]);
        end

        // R5 single buffer off / on, routing untouched
        put(3'd2, 4'b1011);
        chk("R5 buf off", buf_en, 8'hFB);
        chk("R5 route kept", sel_of(2), 3'd7);
        put(3'd2, 4'b1100);
        chk("R5 buf on", buf_en, 8'hFF);

        // R6 all off then on
        put(3'd4, 4'b1101);
        chk("R6 all off", buf_en, 8'h00);
        put(3'd4, 4'b1110);
        chk("R6 all on again", buf_en, 8'hFF);

        // R10 reserved codes
        put(3'd6, 4'b0100);
        pulse_latch();
        chk("R3 out6 route", sel_of(6), 3'd4);
        put(3'd6, 4'b1001);
        put(3'd6, 4'b1010);
        pulse_latch();
        chk("R10 reserved route", sel_of(6), 3'd4);
        chk("R10 reserved gnd", gnd_sel[6], 1'b0);
        chk("R10 reserved buf", buf_en, 8'hFF);

        // R2 chip enables block the strobe
        ce = 1'b0;
        put(3'd0, 4'b0011);
        pulse_latch();
        chk("R2 ce low ignored", sel_of(0), 3'd5);
        ce = 1'b1; ce_n = 1'b1;
        put(3'd0, 4'b0011);
        put(3'd1, 4'b1101);
        pulse_latch();
        chk("R2 ce_n high ignored", sel_of(0), 3'd5);
        chk("R2 ce_n high no buf cmd", buf_en, 8'hFF);
        ce_n = 1'b0;

        // R8 staged write invisible until edge
        put(3'd0, 4'b0001);
        idle(4);
        chk("R8 no edge no change", sel_of(0), 3'd5);
        pulse_latch();
        chk("R8 edge loads", sel_of(0), 3'd1);

        // R7 software transfer with latch high
        put(3'd1, 4'b0100);
        chk("R8 staged only", sel_of(1), 3'd0);
        put(3'd0, 4'b1111);
        chk("R7 sw xfer latch high", sel_of(1), 3'd4);
        latch = 1'b0;
        idle(4);
        put(3'd1, 4'b0110);
        put(3'd3, 4'b1111);
        chk("R7 sw xfer latch low ignored", sel_of(1), 3'd4);
        latch = 1'b1;
        idle(5);
        chk("R8 rising edge loads", sel_of(1), 3'd6);

        // R11 several writes, one edge, same cycle
        put(3'd1, 4'b0010);
        put(3'd4, 4'b0101);
        latch = 1'b0;
        idle(4);
        latch = 1'b1;
        begin
            int c1 = -1;
            int c4 = -1;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (c1 < 0 && sel_of(1) == 3'd2) c1 = k;
                if (c4 < 0 && sel_of(4) == 3'd5) c4 = k;
            end
            chk("R11 out1 updated", (c1 >= 0), 1);
            chk("R11 same cycle", c1, c4);
        end

        // R9 level mode
        edge_mode = 1'b0;
        idle(4);
        put(3'd7, 4'b0001);
        chk("R9 held while high", sel_of(7), 3'd6);
        latch = 1'b0;
        idle(5);
        chk("R9 transparent low", sel_of(7), 3'd1);
        put(3'd7, 4'b0100);
        chk("R9 follows write", sel_of(7), 3'd4);
        latch = 1'b1;
        idle(4);
        put(3'd7, 4'b0010);
        chk("R9 held again", sel_of(7), 3'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule